// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32.768 kHz timebase, delivered as a one-cycle enable pulse in the system clock domain, into a programmable stream of periodic interrupt events. A free-running counter advances on every timebase pulse. A 4-bit rate code picks a power-of-two period from that count, and an enable bit gates event generation. Each event lands where the free-running count reaches a whole multiple of the selected period. The moment the rate was programmed does not affect where the event falls.

At each event the block sets two sticky status flags: a periodic flag and a summary interrupt-request flag. It also drives a level interrupt line high. The register wrapper pulses a clear strobe when software reads the status register. That strobe drops both flags and the line. Bus decode, calendar logic and interrupt coalescing belong to neighbouring blocks.

Top module: `periodic_rate_gen`

## Requirements
- R1: After reset, both status flags and the interrupt line are 0 and the free-running count is 0.
- R2: A rate code of 0 produces no events, whatever the enable bit is.
- R3: With the enable bit low, no events occur for any rate code.
- R4: For rate codes 3 to 15 the period is 2^(code-1) timebase pulses. Code 3 gives 4 pulses and code 15 gives 16384.
- R5: Rate code 1 behaves as code 8 (128 pulses) and rate code 2 behaves as code 9 (256 pulses).
- R6: An event occurs on the timebase pulse that takes the free-running count, counted from reset and wrapping at 2^15, to a multiple of the period. Enabling partway through a period does not restart the phase.
- R7: The clock edge that closes the event's cycle sets the periodic flag, the request flag and the interrupt line to 1.
- R8: A clear strobe returns both flags and the line to 0 on the next edge. If an event and a clear fall in the same cycle, the event wins and the flags end up set.
- R9: The count advances only on timebase pulses, and the flags stay unchanged in cycles with neither an event nor a clear.
- R10: A change of rate code or enable never creates an event by itself. The next event falls on the next aligned boundary of the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle pulse per 32.768 kHz timebase period |
| rate_code | input | 4 | Rate select code, 0 disables |
| per_en | input | 1 | Periodic interrupt enable |
| flag_clr | input | 1 | Clear strobe from a status register read |
| stat_irqf | output | 1 | Sticky interrupt-request flag |
| stat_pf | output | 1 | Sticky periodic flag |
| irq | output | 1 | Interrupt line, active high |

## Verification
The bench targets the aliased codes 1 and 2. A design that decoded them literally would fire every 1 or 2 pulses instead of every 128 or 256. It also enables the block at a count that is not aligned and then changes the rate partway through a period. A design that reloaded a down-counter on programming would fire at the wrong count, or would fire at once on the change. The bench holds the clear strobe high across event cycles to expose a clear that takes priority over the set. It also spaces timebase pulses several clocks apart to catch a counter that advances on the system clock.

// File: rtl/prg_pkg.sv
package prg_pkg;
  localparam int PRG_CNT_W  = 15;
  localparam int PRG_CODE_W = 4;

  // Exponent of the period: aliased codes 1 and 2 map upward.
  function automatic logic [PRG_CODE_W-1:0] rate_shift(input logic [PRG_CODE_W-1:0] code);
    logic [PRG_CODE_W-1:0] s;
    if (code == 4'd1)      s = 4'd7;
    else if (code == 4'd2) s = 4'd8;
    else                   s = code - 4'd1;
    return s;
  endfunction

  // Mask covering the low 'shift' bits of the free-running count.
  function automatic logic [PRG_CNT_W-1:0] period_mask(input logic [PRG_CODE_W-1:0] shift);
    logic [PRG_CNT_W-1:0] m;
    for (int i = 0; i < PRG_CNT_W; i++) begin
      m[i] = (i < int'(shift));
    end
    return m;
  endfunction
endpackage

// File: rtl/prg_divider.sv
module prg_divider #(
  parameter int CNT_W = prg_pkg::PRG_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_next_o = cnt_q + 1'b1;
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_next_o;
  end
endmodule

// File: rtl/prg_rate_decode.sv
module prg_rate_decode #(
  parameter int CNT_W  = prg_pkg::PRG_CNT_W,
  parameter int CODE_W = prg_pkg::PRG_CODE_W
) (
  input  logic [CODE_W-1:0] rate_code_i,
  input  logic              per_en_i,
  output logic              active_o,
  output logic [CNT_W-1:0]  mask_o
);
  import prg_pkg::*;
  logic [CODE_W-1:0] shift;

  always_comb begin
    shift    = rate_shift(rate_code_i);
    mask_o   = period_mask(shift);
    active_o = per_en_i && (rate_code_i != '0);
  end
endmodule

// File: rtl/prg_flag_ctrl.sv
module prg_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irqf_o,
  output logic pf_o,
  output logic irq_o
);
  logic irqf_q, pf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irqf_q <= 1'b0;
      pf_q   <= 1'b0;
    end else if (set_i) begin
      irqf_q <= 1'b1;
      pf_q   <= 1'b1;
    end else if (clr_i) begin
      irqf_q <= 1'b0;
      pf_q   <= 1'b0;
    end
  end

  assign irqf_o = irqf_q;
  assign pf_o   = pf_q;
  assign irq_o  = irqf_q;
endmodule

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen #(
  parameter int CNT_W  = prg_pkg::PRG_CNT_W,
  parameter int CODE_W = prg_pkg::PRG_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              per_en,
  input  logic              flag_clr,
  output logic              stat_irqf,
  output logic              stat_pf,
  output logic              irq
);
  logic [CNT_W-1:0] cnt_w, cnt_next_w, mask_w;
  logic             active_w;
  logic             boundary_w;

  prg_divider #(.CNT_W(CNT_W)) div_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_32k),
    .cnt_o(cnt_w), .cnt_next_o(cnt_next_w)
  );

  prg_rate_decode #(.CNT_W(CNT_W), .CODE_W(CODE_W)) dec_i (
    .rate_code_i(rate_code), .per_en_i(per_en),
    .active_o(active_w), .mask_o(mask_w)
  );

  // Event when this pulse brings the count to a multiple of the period.
  assign boundary_w = tick_32k && active_w && ((cnt_next_w & mask_w) == '0);

  prg_flag_ctrl flg_i (
    .clk(clk), .rst_n(rst_n), .set_i(boundary_w), .clr_i(flag_clr),
    .irqf_o(stat_irqf), .pf_o(stat_pf), .irq_o(irq)
  );
endmodule

// File: rtl/prg_checker.sv
module prg_checker #(
  parameter int CNT_W  = prg_pkg::PRG_CNT_W,
  parameter int CODE_W = prg_pkg::PRG_CODE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [CODE_W-1:0] rate_code,
  input logic              per_en,
  input logic              flag_clr,
  input logic              boundary,
  input logic [CNT_W-1:0]  cnt,
  input logic              stat_pf,
  input logic              stat_irqf,
  input logic              irq
);
  assert_off_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code == '0) |-> !boundary);

  assert_off_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !per_en |-> !boundary);

  assert_event_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (stat_pf && stat_irqf && irq));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !boundary) |=> (!stat_pf && !stat_irqf && !irq));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!boundary && !flag_clr) |=> ($stable(stat_pf) && $stable(stat_irqf)));

  assert_no_tick_no_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> !boundary);

  assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
endmodule

bind periodic_rate_gen prg_checker #(.CNT_W(CNT_W), .CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick_32k), .rate_code(rate_code),
  .per_en(per_en), .flag_clr(flag_clr), .boundary(boundary_w), .cnt(cnt_w),
  .stat_pf(stat_pf), .stat_irqf(stat_irqf), .irq(irq)
);

// File: tb/periodic_rate_gen_tb.sv
module periodic_rate_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       per_en = 1'b0;
  logic       flag_clr = 1'b0;
  logic       stat_irqf, stat_pf, irq;

  int total = 0;
  int bad = 0;
  int mcnt = 0;
  bit m_flag = 1'b0;
  string cur_req = "R1";

  typedef struct {
    bit    irqf;
    bit    pf;
    bit    irq;
    string tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  periodic_rate_gen dut_i (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_code(rate_code),
    .per_en(per_en), .flag_clr(flag_clr), .stat_irqf(stat_irqf),
    .stat_pf(stat_pf), .irq(irq)
  );

  function automatic int bench_period(input int c);
    int e;
    int p;
    e = (c == 1) ? 7 : (c == 2) ? 8 : c - 1;
    p = 1;
    repeat (e) p = p * 2;
    return p;
  endfunction

  task automatic check(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, expv, $time);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected outputs.
  task automatic cyc(input bit tk, input bit clr);
    bit ev;
    exp_t e;
    @(negedge clk);
    tick_32k = tk;
    flag_clr = clr;
    ev = tk && per_en && (rate_code != 0) &&
         (((mcnt + 1) % bench_period(int'(rate_code))) == 0);
    if (tk) mcnt = (mcnt + 1) % 32768;
    if (ev) m_flag = 1'b1;
    else if (clr) m_flag = 1'b0;
    e.irqf = m_flag; e.pf = m_flag; e.irq = m_flag; e.tag = cur_req;
    q.push_back(e);
  endtask

  // clr_mode: 0 never clear, 1 clear when the model flag is set, 2 always.
  task automatic run(input int n, input int every, input int clr_mode);
    for (int i = 0; i < n; i++) begin
      cyc((i % every) == 0, (clr_mode == 2) || (clr_mode == 1 && m_flag));
    end
  endtask

  task automatic set_rate(input int c, input bit en);
    @(negedge clk);
    tick_32k = 1'b0;
    flag_clr = 1'b0;
    rate_code = 4'(c);
    per_en = en;
  endtask

  // Monitor: compares outputs after each edge with the oldest expectation.
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      check({e.tag, " irqf"}, int'(stat_irqf), int'(e.irqf));
      check({e.tag, " pf"}, int'(stat_pf), int'(e.pf));
      check({e.tag, " irq"}, int'(irq), int'(e.irq));
    end
  end

  initial begin
    #1_900_000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 irq", int'(irq), 0);
    check("R1 pf", int'(stat_pf), 0);
    check("R1 irqf", int'(stat_irqf), 0);
    cur_req = "R1";
    run(3, 100, 0);

    // R4/R7: code 3, flags held without clear, then cleared
    cur_req = "R7"; set_rate(3, 1'b1); run(12, 1, 0);
    cur_req = "R4"; run(40, 1, 1);
    // R8: clear held high across events, set wins
    cur_req = "R8"; run(30, 1, 2);
    run(2, 1, 2);
    // R2: code 0 with enable
    cur_req = "R2"; set_rate(0, 1'b1); run(300, 1, 2); run(300, 1, 0);
    // R3: enable low
    cur_req = "R3"; set_rate(5, 1'b0); run(300, 1, 0);
    // R5: aliased codes
    cur_req = "R5"; set_rate(1, 1'b1); run(600, 1, 1);
    set_rate(2, 1'b1); run(900, 1, 1);
    // R9: sparse timebase pulses
    cur_req = "R9"; set_rate(4, 1'b1); run(200, 3, 1);
    // R6: enable at a misaligned count
    cur_req = "R6"; set_rate(6, 1'b0); run(13, 1, 1);
    set_rate(6, 1'b1); run(150, 1, 1);
    // R10: change rate partway through periods
    cur_req = "R10"; set_rate(7, 1'b1); run(37, 1, 1);
    set_rate(3, 1'b1); run(21, 1, 1);
    set_rate(9, 1'b1); run(5, 1, 1);
    set_rate(9, 1'b0); run(3, 1, 1);
    set_rate(9, 1'b1); run(700, 1, 1);
    // R4: sweep codes 3..15
    cur_req = "R4";
    for (int c = 3; c <= 15; c++) begin
      set_rate(c, 1'b1);
      run(2 * bench_period(c) + 5, 1, 1);
    end
    set_rate(0, 1'b0);
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule